// File: doc/BRIEF.md
# Stereo Sample FIFO Host Interface

This block is the microcontroller-facing write port of an audio playback engine. A host drives an active-low chip select, write and read strobes, a data/command line and a channel line. Data writes fill one of two 16-entry sample FIFOs, one for each channel. Command writes load a six-bit configuration word, and status reads return an eight-bit summary of both FIFOs. All strobes are sampled on the rising clock edge. Each clock cycle in which a strobe is low counts as one bus access.

The FIFO named by the channel line drives three level flags: empty, more-than-half and full. Each channel also has a DMA request output and an acknowledge input. Command bits set the polarity of the flags, the requests and the acknowledges. Playback of a channel starts once that FIFO first passes half occupancy. Playback then lets a downstream consumer pop samples, through a simple pop/head port that stands in for the synthesis engine. An active-low busy output shows that playback is under way.

Top module: `stereo_fifo_host`

## Requirements
- R1: While `cs_n` is high, `wr_n` and `rd_n` have no effect: no FIFO changes, the configuration is unchanged and `dout` is 0.
- R2: A write with `dc`=0 loads the configuration from `din[5:0]`: bit0 stereo, bit1 DMA, bit2 16-bit width, bit3 flag inversion, bit4 request inversion, bit5 acknowledge-high. Reset clears all six bits. A read with `dc`=0 drives `dout` = {0, full_r, half_r, empty_r, full_l, half_l, empty_l, playing}. These flag bits are never inverted. `dout` is 0 at all other times.
- R3: For the selected FIFO holding n samples, the raw flags are empty = (n==0), half = (n>8) and full = (n==16). A write shows in the flags one cycle after its strobe.
- R4: A sample that arrives while its FIFO is full is discarded, and the stored samples and their order are unchanged.
- R5: When configuration bit3 is set, all three flag outputs are inverted. When bit4 is set, both request outputs are inverted.
- R6: In stereo mode, `ch`=1 routes data writes to the right FIFO and shows its flags, and `ch`=0 does the same for the left FIFO. In mono mode every write goes to the left FIFO and the flags show the left FIFO, whatever `ch` is.
- R7: The raw request of each channel is (DMA mode and that FIFO not full). In DMA mode a data write is accepted only while the target channel's acknowledge is asserted: low by default, high when bit5 is set. A write that is not accepted leaves the byte phase unchanged.
- R8: A channel starts playing one cycle after its half flag first becomes raw-true, and it stays playing until reset. `busy_n` is low while either channel plays. A pop is ignored unless that channel plays and holds data. `sample_l`/`sample_r` show the oldest sample of each FIFO.
- R9: In 16-bit mode each data write stores `din[15:0]` as one sample.
- R10: In 8-bit mode two accepted data writes form one sample: the first write gives the low byte and the second gives the high byte, both from `din[7:0]`. A command write returns the byte phase to "low byte next".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| dc | input | 1 | 1 = sample data, 0 = command/status |
| ch | input | 1 | Channel select, 1 = right |
| din | input | 16 | Host write bus |
| dout | output | 8 | Status byte during a status read, otherwise 0 |
| fifo_empty | output | 1 | Empty flag of the selected FIFO |
| fifo_half | output | 1 | More-than-half flag of the selected FIFO |
| fifo_full | output | 1 | Full flag of the selected FIFO |
| busy_n | output | 1 | Low while either channel plays |
| dreq_l | output | 1 | Left DMA request |
| dreq_r | output | 1 | Right DMA request |
| dack_l | input | 1 | Left DMA acknowledge |
| dack_r | input | 1 | Right DMA acknowledge |
| pop_l | input | 1 | Consumer pop, left |
| pop_r | input | 1 | Consumer pop, right |
| sample_l | output | 16 | Oldest left sample |
| sample_r | output | 16 | Oldest right sample |

## Verification
A corrupted FIFO count shows at the flag pins and in the status byte on the cycle after the access that caused it. It appears first at the 0, 8/9 and 16 occupancy boundaries, which the bench crosses one sample at a time on both channels. A pointer error shows as a wrong `sample_l`/`sample_r` value on the next pop. A stuck byte phase makes the following 8-bit sample pair its bytes wrongly. A wrong configuration bit shows at once as inverted pins, misrouted writes or ignored DMA writes.

// File: rtl/sfh_pkg.sv
package sfh_pkg;
    // Configuration word; packed so that cfg_t'(din[5:0]) places bit0 in stereo.
    typedef struct packed {
        logic dack_hi;
        logic dreq_inv;
        logic flag_inv;
        logic wide;
        logic dma;
        logic stereo;
    } cfg_t;
endpackage

// File: rtl/sfh_fifo.sv
module sfh_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       half,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign empty   = (st_q.cnt == '0);
    assign full    = (st_q.cnt == CW'(DEPTH));
    assign half    = (st_q.cnt > CW'(DEPTH / 2));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem_q[st_q.rp];
    assign count   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (push_ok) st_d.wp = st_q.wp + 1'b1;
        if (pop_ok)  st_d.rp = st_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wp] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)) && $stable(st_q.wp)); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty && $stable(st_q.rp)); // R8
endmodule

// File: rtl/sfh_pins.sv
module sfh_pins (
    input  logic sel_r,
    input  logic flag_inv,
    input  logic dreq_inv,
    input  logic dma,
    input  logic empty_l,
    input  logic half_l,
    input  logic full_l,
    input  logic empty_r,
    input  logic half_r,
    input  logic full_r,
    output logic fifo_empty,
    output logic fifo_half,
    output logic fifo_full,
    output logic dreq_l,
    output logic dreq_r
);
    logic [2:0] raw_sel;

    always_comb begin
        raw_sel    = sel_r ? {empty_r, half_r, full_r} : {empty_l, half_l, full_l};
        fifo_empty = raw_sel[2] ^ flag_inv;
        fifo_half  = raw_sel[1] ^ flag_inv;
        fifo_full  = raw_sel[0] ^ flag_inv;
        dreq_l     = (dma && !full_l) ^ dreq_inv;
        dreq_r     = (dma && !full_r) ^ dreq_inv;
    end
endmodule

// File: rtl/stereo_fifo_host.sv
module stereo_fifo_host
    import sfh_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         wr_n,
    input  logic         rd_n,
    input  logic         dc,
    input  logic         ch,
    input  logic [W-1:0] din,
    output logic [7:0]   dout,
    output logic         fifo_empty,
    output logic         fifo_half,
    output logic         fifo_full,
    output logic         busy_n,
    output logic         dreq_l,
    output logic         dreq_r,
    input  logic         dack_l,
    input  logic         dack_r,
    input  logic         pop_l,
    input  logic         pop_r,
    output logic [W-1:0] sample_l,
    output logic [W-1:0] sample_r
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        cfg_t       cfg;
        logic       phase;
        logic [7:0] lo;
        logic       play_l;
        logic       play_r;
    } host_st_t;

    host_st_t st_q, st_d;
    logic wr_cyc, rd_cyc, sel_r, ack_l, ack_r, dma_ok, cmd_wr, data_wr;
    logic push;
    logic [W-1:0] sample_in;
    logic empty_l, half_l, full_l, empty_r, half_r, full_r;
    logic [CW-1:0] cnt_l, cnt_r;

    assign wr_cyc  = !cs_n && !wr_n;
    assign rd_cyc  = !cs_n && !rd_n;
    assign sel_r   = st_q.cfg.stereo && ch;
    assign ack_l   = st_q.cfg.dack_hi ? dack_l : !dack_l;
    assign ack_r   = st_q.cfg.dack_hi ? dack_r : !dack_r;
    assign dma_ok  = !st_q.cfg.dma || (sel_r ? ack_r : ack_l);
    assign cmd_wr  = wr_cyc && !dc;
    assign data_wr = wr_cyc && dc && dma_ok;

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        sample_in = '0;
        if (cmd_wr) begin
            st_d.cfg   = cfg_t'(din[5:0]);
            st_d.phase = 1'b0;
        end else if (data_wr) begin
            if (st_q.cfg.wide) begin
                push      = 1'b1;
                sample_in = din;
            end else if (!st_q.phase) begin
                st_d.lo    = din[7:0];
                st_d.phase = 1'b1;
            end else begin
                push       = 1'b1;
                sample_in  = W'({din[7:0], st_q.lo});
                st_d.phase = 1'b0;
            end
        end
        st_d.play_l = st_q.play_l || half_l;
        st_d.play_r = st_q.play_r || half_r;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sfh_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo_l (
        .clk(clk), .rst_n(rst_n), .push(push && !sel_r), .wdata(sample_in),
        .pop(pop_l && st_q.play_l), .head(sample_l), .count(cnt_l),
        .empty(empty_l), .half(half_l), .full(full_l)
    );

    sfh_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo_r (
        .clk(clk), .rst_n(rst_n), .push(push && sel_r), .wdata(sample_in),
        .pop(pop_r && st_q.play_r), .head(sample_r), .count(cnt_r),
        .empty(empty_r), .half(half_r), .full(full_r)
    );

    sfh_pins u_pins (
        .sel_r(sel_r), .flag_inv(st_q.cfg.flag_inv), .dreq_inv(st_q.cfg.dreq_inv),
        .dma(st_q.cfg.dma), .empty_l(empty_l), .half_l(half_l), .full_l(full_l),
        .empty_r(empty_r), .half_r(half_r), .full_r(full_r),
        .fifo_empty(fifo_empty), .fifo_half(fifo_half), .fifo_full(fifo_full),
        .dreq_l(dreq_l), .dreq_r(dreq_r)
    );

    assign busy_n = !(st_q.play_l || st_q.play_r);
    assign dout   = (rd_cyc && !dc)
                  ? {1'b0, full_r, half_r, empty_r, full_l, half_l, empty_l,
                     st_q.play_l || st_q.play_r}
                  : 8'h00;

    AST_CS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(st_q.cfg) && $stable(st_q.phase)); // R1
    AST_PLAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.play_l && st_q.play_r) |=> !busy_n); // R8
    AST_PLAY_HOLD_L: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.play_l |=> st_q.play_l); // R8
    AST_MONO_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.cfg.stereo |=> cnt_r <= $past(cnt_r)); // R6
    AST_DREQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cfg.dma && full_r) |-> (dreq_r == st_q.cfg.dreq_inv)); // R7
endmodule

// File: tb/stereo_fifo_host_bench.sv
module stereo_fifo_host_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, dc = 1'b0, ch = 1'b0;
    logic [15:0] din = '0;
    logic [7:0] dout;
    logic fifo_empty, fifo_half, fifo_full, busy_n, dreq_l, dreq_r;
    logic dack_l = 1'b1, dack_r = 1'b1, pop_l = 1'b0, pop_r = 1'b0;
    logic [15:0] sample_l, sample_r;

    int checks = 0;
    int fails  = 0;

    // bench model
    logic [15:0] ql[$];
    logic [15:0] qr[$];
    logic m_st = 0, m_dma = 0, m_wide = 0, m_finv = 0, m_dinv = 0, m_ahi = 0;
    logic m_ph = 0, m_pl = 0, m_pr = 0;
    logic [7:0] m_lo = '0;

    always #2.5 clk = ~clk;

    stereo_fifo_host u_stereo_fifo_host (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .dc(dc), .ch(ch),
        .din(din), .dout(dout), .fifo_empty(fifo_empty), .fifo_half(fifo_half),
        .fifo_full(fifo_full), .busy_n(busy_n), .dreq_l(dreq_l), .dreq_r(dreq_r),
        .dack_l(dack_l), .dack_r(dack_r), .pop_l(pop_l), .pop_r(pop_r),
        .sample_l(sample_l), .sample_r(sample_r)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_cmd(input logic [7:0] v);
        m_st = v[0]; m_dma = v[1]; m_wide = v[2];
        m_finv = v[3]; m_dinv = v[4]; m_ahi = v[5]; m_ph = 0;
    endtask

    task automatic model_write(input logic c, input logic [15:0] v);
        logic t, ack;
        logic [15:0] s;
        t   = m_st & c;
        ack = m_ahi ? (t ? dack_r : dack_l) : !(t ? dack_r : dack_l);
        if (m_dma && !ack) return;
        if (!m_wide) begin
            if (!m_ph) begin m_lo = v[7:0]; m_ph = 1; return; end
            s = {v[7:0], m_lo}; m_ph = 0;
        end else s = v;
        if (t) begin
            if (qr.size() < 16) qr.push_back(s);
            if (qr.size() > 8) m_pr = 1;
        end else begin
            if (ql.size() < 16) ql.push_back(s);
            if (ql.size() > 8) m_pl = 1;
        end
    endtask

    task automatic do_cmd(input logic [7:0] v);
        @(negedge clk); cs_n = 0; dc = 0; din = {8'h00, v}; wr_n = 0;
        @(negedge clk); wr_n = 1; cs_n = 1;
        model_cmd(v);
    endtask

    task automatic do_write(input logic c, input logic [15:0] v);
        @(negedge clk); cs_n = 0; dc = 1; ch = c; din = v; wr_n = 0;
        @(negedge clk); wr_n = 1; cs_n = 1;
        @(negedge clk);
        model_write(c, v);
    endtask

    task automatic do_pop(input logic c);
        @(negedge clk); if (c) pop_r = 1; else pop_l = 1;
        @(negedge clk); pop_l = 0; pop_r = 0;
        if (c) begin if (m_pr && qr.size() > 0) void'(qr.pop_front()); end
        else   begin if (m_pl && ql.size() > 0) void'(ql.pop_front()); end
    endtask

    task automatic check_all(input logic c, input string tag);
        int n;
        logic [2:0] ef;
        ch = c; #1;
        n  = (m_st & c) ? qr.size() : ql.size();
        ef = {n == 0, n > 8, n == 16};
        chk({tag, " flags"}, {13'd0, fifo_empty, fifo_half, fifo_full},
            {13'd0, ef ^ {3{m_finv}}});
        chk({tag, " dreq R7"}, {14'd0, dreq_l, dreq_r},
            {14'd0, (m_dma && ql.size() < 16) ^ m_dinv, (m_dma && qr.size() < 16) ^ m_dinv});
        chk({tag, " busy R8"}, {15'd0, busy_n}, {15'd0, !(m_pl || m_pr)});
        if (ql.size() > 0) chk({tag, " head_l R8"}, sample_l, ql[0]);
        if (qr.size() > 0) chk({tag, " head_r R8"}, sample_r, qr[0]);
    endtask

    task automatic check_status(input string tag);
        logic [7:0] e;
        e = {1'b0, qr.size() == 16, qr.size() > 8, qr.size() == 0,
             ql.size() == 16, ql.size() > 8, ql.size() == 0, m_pl || m_pr};
        @(negedge clk); cs_n = 0; dc = 0; rd_n = 0; #1;
        chk({tag, " status R2"}, {8'h00, dout}, {8'h00, e});
        @(negedge clk); rd_n = 1; cs_n = 1; #1;
        chk({tag, " idle dout R2"}, {8'h00, dout}, 16'h0000);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all(0, "reset R3");
        check_status("reset");

        // R6 R3 R4: stereo, 16-bit, fill right past full
        do_cmd(8'h05);
        for (int k = 1; k <= 17; k++) begin
            do_write(1, 16'h1000 + 16'(k));
            check_all(1, "R3 right fill");
            check_all(0, "R6 left untouched");
        end
        check_status("full right R4");
        for (int k = 1; k <= 17; k++) begin
            do_pop(1);
            check_all(1, "R4 R8 drain right");
        end

        // R1: strobes with chip select high
        @(negedge clk); cs_n = 1; dc = 1; ch = 0; din = 16'hBEEF; wr_n = 0;
        @(negedge clk); dc = 0; din = 16'h003F;
        @(negedge clk); wr_n = 1; rd_n = 0; #1;
        chk("R1 dout with cs_n high", {8'h00, dout}, 16'h0000);
        @(negedge clk); rd_n = 1;
        check_all(0, "R1 ignored");
        check_all(1, "R1 ignored");

        // R6: mono forces left; R8 pop ignored before playing
        do_cmd(8'h04);
        for (int k = 0; k < 3; k++) do_write(1, 16'h2000 + 16'(k));
        check_all(1, "R6 mono routing");
        do_pop(0);
        check_all(0, "R8 pop before play");
        check_status("mono R6");

        // R5: inversion
        do_cmd(8'h1C);
        check_all(0, "R5 inverted");
        check_all(1, "R5 inverted");

        // R7: DMA, acknowledge active low
        do_cmd(8'h06);
        dack_l = 1; do_write(0, 16'h3001); check_all(0, "R7 no ack low");
        dack_l = 0; do_write(0, 16'h3002); check_all(0, "R7 ack low");
        // acknowledge active high
        do_cmd(8'h26);
        dack_l = 0; do_write(0, 16'h3003); check_all(0, "R7 no ack high");
        dack_l = 1;
        for (int k = 0; k < 14; k++) begin
            do_write(0, 16'h4000 + 16'(k));
            check_all(0, "R7 R3 fill left");
        end
        do_cmd(8'h36);
        check_all(0, "R7 dreq inverted full");
        for (int k = 0; k < 16; k++) begin
            do_pop(0);
            check_all(0, "R8 drain left");
        end

        // R10: 8-bit pairing and phase reset, mono
        dack_l = 1;
        do_cmd(8'h00);
        do_write(0, 16'hFF34); check_all(0, "R10 low byte only");
        do_write(0, 16'hEE12); check_all(0, "R10 pair");
        do_write(0, 16'h0077);
        do_cmd(8'h00);
        do_write(0, 16'h00CD);
        do_write(0, 16'h00AB); check_all(0, "R10 phase reset");
        // stereo 8-bit into right
        do_cmd(8'h01);
        do_write(1, 16'h0056); do_write(1, 16'h0078);
        check_all(1, "R10 R6 right bytes");
        // R9: 16-bit into left
        do_cmd(8'h05);
        do_write(0, 16'hA5C3); check_all(0, "R9 wide");
        for (int k = 0; k < 4; k++) begin
            do_pop(0);
            check_all(0, "R8 R9 R10 order");
        end
        check_status("final");
        summary();
    end
endmodule